// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the timing for a multiplexed LCD segment driver. It counts ticks from one of two clock-enable sources, an on-chip oscillator tick or an externally supplied clock tick, and turns them into frames. A 3-bit rate code picks the number of ticks in one frame. The mapping is not a power of two, and it shrinks by a factor of eight when the external source is declared to run at its slow rate. Each frame is divided into one equal period per common line, with three or four commons. Each common period is divided into two equal halves of opposite drive polarity.

The outputs are the index of the active common, a polarity flag for the current half-period, a one-cycle frame-start strobe and a blanking flag. The blanking flag tells the output stage to pull every segment and common to ground. The settings are captured only at frame boundaries, so a frame always runs to its full length with the settings it started with. All pins are plain level or strobe signals. There is no data stream, so the block has no valid/ready handshake.

Top module: `lcd_frame_timer`

## Requirements
- R1: When `ext_clk_sel`=0, or when `ext_clk_sel`=1 with `ext_slow`=0, `rate_code` 0,1,2,3,4,5,6 gives a frame of 6144, 4608, 3072, 2304, 1536, 1152 and 768 ticks.
- R2: When `ext_clk_sel`=1 and `ext_slow`=1, `rate_code` 0..6 gives a frame of 768, 576, 384, 288, 192, 144 and 96 ticks.
- R3: `rate_code`=7 gives the same frame length as `rate_code`=2 in every source mode.
- R4: `ext_clk_sel`=0 counts only `int_tick`. `ext_clk_sel`=1 counts only `ext_tick`. Pulses on the unselected tick input have no effect.
- R5: When `ext_clk_sel`=0, `ext_slow` has no effect on the frame length.
- R6: `four_com`=0 selects three commons and `four_com`=1 selects four. `com_idx` steps 0,1,..,last and wraps to 0. Each common lasts frame_ticks/commons ticks.
- R7: `pol` is 0 during the first half of every common period and 1 during the second half. The two halves are equal.
- R8: `frame_start` is high for exactly one clock cycle. It rises in the cycle in which `com_idx` wraps back to 0, and it is never high unless `com_idx`=0 and `pol`=0.
- R9: `rate_code`, `ext_clk_sel`, `ext_slow` and `four_com` are captured only during reset and at the tick that ends a frame. A change made mid-frame first takes effect in the following frame.
- R10: `blank` is high while `rst` is high. Otherwise `blank` equals the inverse of `disp_en` one clock earlier.
- R11: A synchronous reset clears the counters, sets `com_idx`=0 and `pol`=0 and clears `frame_start`. The first frame after release has the full length.
- R12: In any cycle without a tick from the selected source, `com_idx` and `pol` hold and `frame_start` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_tick | input | 1 | One-cycle enable from the on-chip oscillator |
| ext_tick | input | 1 | One-cycle enable from the external clock |
| ext_clk_sel | input | 1 | 0: count `int_tick`, 1: count `ext_tick` |
| ext_slow | input | 1 | With external source: 1 declares the slow clock rate |
| rate_code | input | 3 | Frame length code |
| four_com | input | 1 | 0: three commons, 1: four commons |
| disp_en | input | 1 | Display enable, low forces blanking |
| com_idx | output | 2 | Index of the active common |
| pol | output | 1 | Half-period polarity of the drive |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| blank | output | 1 | Force all segment and common outputs to ground |

## Verification
The tick that ends a frame is also the tick that loads new settings, so the wrap of `com_idx` and a settings change can fall on the same edge. The bench provokes this by changing the rate code and the number of commons a hundred cycles into a running frame. It then checks that the current frame still ends after its old length and that the next frame has the new length and common count. A second overlap is a reset that arrives while ticks keep coming. The bench judges it by requiring cleared outputs during the reset cycle and a full-length first frame after release.

// File: rtl/lcdft_pkg.sv
package lcdft_pkg;
  localparam int FDIV_W = 13;
  localparam int CODE_W = 3;
  localparam int COM_W  = 2;

  typedef struct packed {
    logic              use_ext;
    logic              slow;
    logic [CODE_W-1:0] code;
    logic              four;
  } lcd_cfg_t;

  // Frame length in ticks: even codes 6144>>n, odd codes 4608>>n, code 7 aliases code 2,
  // slow external source divides by eight.
  function automatic logic [FDIV_W-1:0] frame_ticks(input logic [CODE_W-1:0] code,
                                                    input logic slow);
    logic [CODE_W-1:0] eff;
    logic [FDIV_W-1:0] base;
    logic [FDIV_W-1:0] len;
    eff  = (code == CODE_W'(7)) ? CODE_W'(2) : code;
    base = eff[0] ? FDIV_W'(4608) : FDIV_W'(6144);
    len  = base >> eff[CODE_W-1:1];
    if (slow) len = len >> 3;
    return len;
  endfunction
endpackage

// File: rtl/lcdft_cfg_reg.sv
module lcdft_cfg_reg
  import lcdft_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              ext_clk_sel,
  input  logic              ext_slow,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              four_com,
  output lcd_cfg_t          cfg_q
);
  logic load;
  assign load = rst | frame_end;

  always_ff @(posedge clk) begin
    if (load) begin
      cfg_q.use_ext <= ext_clk_sel;
      cfg_q.slow    <= ext_clk_sel & ext_slow;
      cfg_q.code    <= rate_code;
      cfg_q.four    <= four_com;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(cfg_q));

  // R5
  slow_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.use_ext |-> !cfg_q.slow);
endmodule

// File: rtl/lcdft_len.sv
module lcdft_len
  import lcdft_pkg::*;
#(
  parameter int DIV_W  = FDIV_W,
  parameter int HALF_W = DIV_W - 2
) (
  input  logic              slow,
  input  logic [CODE_W-1:0] code,
  input  logic              four,
  output logic [HALF_W-1:0] half_len
);
  logic [DIV_W-1:0] flen;

  always_comb begin
    flen = DIV_W'(frame_ticks(code, slow));
    if (four) half_len = HALF_W'(flen >> 3);
    else      half_len = HALF_W'(flen / DIV_W'(6));
  end
endmodule

// File: rtl/lcdft_tick_sel.sv
module lcdft_tick_sel (
  input  logic int_tick,
  input  logic ext_tick,
  input  logic use_ext,
  output logic tick
);
  assign tick = use_ext ? ext_tick : int_tick;
endmodule

// File: rtl/lcdft_seq.sv
module lcdft_seq #(
  parameter int HALF_W = 11,
  parameter int COM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [HALF_W-1:0] half_len,
  input  logic              four,
  output logic [COM_W-1:0]  com_idx,
  output logic              pol,
  output logic              frame_start,
  output logic              frame_end
);
  logic [HALF_W-1:0] half_cnt;
  logic              last_half;
  logic              last_com;

  always_comb begin
    last_half = (half_cnt == half_len - HALF_W'(1));
    last_com  = four ? (com_idx == COM_W'(3)) : (com_idx == COM_W'(2));
    frame_end = tick && last_half && pol && last_com;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt    <= '0;
      pol         <= 1'b0;
      com_idx     <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= frame_end;
      if (tick) begin
        if (last_half) begin
          half_cnt <= '0;
          pol      <= ~pol;
          if (pol) com_idx <= last_com ? '0 : com_idx + COM_W'(1);
        end else begin
          half_cnt <= half_cnt + HALF_W'(1);
        end
      end
    end
  end

  // R6
  com_range_chk: assert property (@(posedge clk) disable iff (rst)
    four || (com_idx != COM_W'(3)));

  // R8
  frame_start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (com_idx == '0) && !pol);

  // R8
  frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(pol) && $stable(com_idx) && !frame_start);
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdft_pkg::*;
#(
  parameter int DIV_W = FDIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_tick,
  input  logic              ext_tick,
  input  logic              ext_clk_sel,
  input  logic              ext_slow,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              four_com,
  input  logic              disp_en,
  output logic [COM_W-1:0]  com_idx,
  output logic              pol,
  output logic              frame_start,
  output logic              blank
);
  localparam int HALF_W = DIV_W - 2;

  lcd_cfg_t          cfg_q;
  logic              tick;
  logic              frame_end;
  logic [HALF_W-1:0] half_len;

  lcdft_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .ext_clk_sel(ext_clk_sel), .ext_slow(ext_slow),
    .rate_code(rate_code), .four_com(four_com), .cfg_q(cfg_q)
  );

  lcdft_len #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_len (
    .slow(cfg_q.slow), .code(cfg_q.code), .four(cfg_q.four), .half_len(half_len)
  );

  lcdft_tick_sel u_tick (
    .int_tick(int_tick), .ext_tick(ext_tick), .use_ext(cfg_q.use_ext), .tick(tick)
  );

  lcdft_seq #(.HALF_W(HALF_W), .COM_W(COM_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .half_len(half_len), .four(cfg_q.four),
    .com_idx(com_idx), .pol(pol), .frame_start(frame_start), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    blank <= rst | ~disp_en;
  end

  // R10
  blank_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (blank == !$past(disp_en)));
endmodule

// File: tb/lcd_frame_timer_tb.sv
module lcd_frame_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;
  localparam int MEAS_LIMIT = 20000;

  // {ext_clk_sel, ext_slow, rate_code[2:0], four_com, frame_ticks[12:0]}
  localparam logic [18:0] VECS [10] = '{
    {1'b0, 1'b0, 3'd6, 1'b0, 13'd768},
    {1'b0, 1'b0, 3'd0, 1'b1, 13'd6144},
    {1'b0, 1'b0, 3'd7, 1'b0, 13'd3072},
    {1'b1, 1'b0, 3'd5, 1'b1, 13'd1152},
    {1'b1, 1'b1, 3'd0, 1'b0, 13'd768},
    {1'b1, 1'b1, 3'd6, 1'b1, 13'd96},
    {1'b1, 1'b1, 3'd7, 1'b1, 13'd384},
    {1'b0, 1'b1, 3'd6, 1'b0, 13'd768},
    {1'b1, 1'b1, 3'd3, 1'b0, 13'd288},
    {1'b1, 1'b0, 3'd1, 1'b0, 13'd4608}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       int_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       ext_clk_sel = 1'b0;
  logic       ext_slow = 1'b0;
  logic [2:0] rate_code = 3'd6;
  logic       four_com = 1'b0;
  logic       disp_en = 1'b1;
  logic [1:0] com_idx;
  logic       pol;
  logic       frame_start;
  logic       blank;

  int checks = 0;
  int errors = 0;
  int nstep = 0;
  int wd = 0;
  bit tick_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_timer dut_i (
    .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
    .ext_clk_sel(ext_clk_sel), .ext_slow(ext_slow), .rate_code(rate_code),
    .four_com(four_com), .disp_en(disp_en), .com_idx(com_idx), .pol(pol),
    .frame_start(frame_start), .blank(blank)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // int_tick every cycle, ext_tick every third cycle
  task automatic cyc();
    @(negedge clk);
    nstep++;
    int_tick = tick_en;
    ext_tick = tick_en && (nstep % 3 == 0);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
  endtask

  task automatic sync_frame(output int waited);
    waited = 0;
    do begin
      cyc();
      waited++;
    end while (!frame_start && waited < MEAS_LIMIT);
  endtask

  task automatic measure(output int flen, output int half, output int ncom, output bit pulse_ok);
    logic [1:0] pc;
    logic       pp;
    flen = 0; half = -1; ncom = 0;
    pc = com_idx; pp = pol;
    cyc();
    flen++;
    pulse_ok = !frame_start;
    while (1) begin
      if (pol && !pp && half < 0) half = flen;
      if (com_idx != pc) ncom++;
      pc = com_idx; pp = pol;
      if (frame_start || flen >= MEAS_LIMIT) break;
      cyc();
      flen++;
    end
  endtask

  initial begin
    int flen, half, ncom, w, tp, div, ncm;
    bit pok;
    string tag;

    // R11 / R10: state during reset
    repeat (3) cyc();
    check(com_idx == 2'd0, "R11 reset com_idx", com_idx, 0);
    check(pol == 1'b0, "R11 reset pol", pol, 0);
    check(frame_start == 1'b0, "R11 reset frame_start", frame_start, 0);
    check(blank == 1'b1, "R10 blank during reset", blank, 1);
    rst = 1'b0;

    // Vector table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 10; i++) begin
      ext_clk_sel = VECS[i][18];
      ext_slow    = VECS[i][17];
      rate_code   = VECS[i][16:14];
      four_com    = VECS[i][13];
      div         = int'(VECS[i][12:0]);
      tp          = ext_clk_sel ? 3 : 1;
      ncm         = four_com ? 4 : 3;
      if (rate_code == 3'd7)              tag = "R3";
      else if (!ext_clk_sel && ext_slow)  tag = "R5";
      else if (ext_clk_sel && ext_slow)   tag = "R2";
      else                                tag = "R1";
      do_reset();
      sync_frame(w);
      measure(flen, half, ncom, pok);
      check(flen == div * tp, $sformatf("%s/R4 frame length vec %0d", tag, i), flen, div * tp);
      check(ncom == ncm, $sformatf("R6 commons per frame vec %0d", i), ncom, ncm);
      check(half == (div / ncm / 2) * tp, $sformatf("R7 first half length vec %0d", i),
            half, (div / ncm / 2) * tp);
      check(pok, $sformatf("R8 frame_start single cycle vec %0d", i), int'(pok), 1);
    end

    // R9: settings changed mid-frame take effect at the next frame
    ext_clk_sel = 1'b0; ext_slow = 1'b0; rate_code = 3'd6; four_com = 1'b0;
    do_reset();
    sync_frame(w);
    repeat (100) cyc();
    rate_code = 3'd0; four_com = 1'b1;
    sync_frame(w);
    check(w == 668, "R9 current frame keeps old length", w, 668);
    measure(flen, half, ncom, pok);
    check(flen == 6144, "R9 next frame new length", flen, 6144);
    check(ncom == 4, "R9 next frame new commons", ncom, 4);

    // R11: reset in the middle of a frame with ticks running
    rate_code = 3'd6; four_com = 1'b0;
    sync_frame(w);
    repeat (300) cyc();
    rst = 1'b1;
    cyc();
    check(com_idx == 2'd0 && pol == 1'b0 && frame_start == 1'b0,
          "R11 mid-run reset clears", {29'd0, com_idx, pol}, 0);
    rst = 1'b0;
    sync_frame(w);
    check(w == 768, "R11 full first frame after reset", w, 768);

    // R12: no ticks, outputs hold
    repeat (200) cyc();
    begin
      logic [1:0] c0;
      logic       p0;
      bit         fs_seen;
      c0 = com_idx; p0 = pol; fs_seen = 0;
      tick_en = 1'b0;
      repeat (50) begin
        cyc();
        if (frame_start) fs_seen = 1;
      end
      check(com_idx == c0 && pol == p0, "R12 hold without ticks",
            {29'd0, com_idx, pol}, {29'd0, c0, p0});
      check(!fs_seen, "R12 no frame_start without ticks", int'(fs_seen), 0);
      tick_en = 1'b1;
    end

    // R4: external selected, ext ticks stopped, int ticks alone must not advance
    ext_clk_sel = 1'b1; ext_slow = 1'b1; rate_code = 3'd6; four_com = 1'b1;
    do_reset();
    repeat (40) begin
      @(negedge clk);
      int_tick = 1'b1;
      ext_tick = 1'b0;
      @(posedge clk);
      #1;
    end
    check(com_idx == 2'd0 && pol == 1'b0, "R4 unselected tick ignored",
          {29'd0, com_idx, pol}, 0);

    // R10: blank follows disp_en with one cycle delay
    disp_en = 1'b0;
    cyc();
    check(blank == 1'b1, "R10 blank when disabled", blank, 1);
    disp_en = 1'b1;
    cyc();
    check(blank == 1'b0, "R10 blank released", blank, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule